// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a synthesizable behavioural model of a byte-wide memory whose cells can be programmed once. A read takes the byte at the presented address and drives it on the data output. Programming takes a data byte and clears bits in the addressed cell. A fresh cell reads 0xFF, and programming can only turn ones into zeros. Two identification bytes can also be read out: one names the maker and one names the device. The full array is 64K by 8. The address width is a parameter, and its default is kept small so that elaboration stays light.

The control pins mirror a classic programmable-memory socket. There is an active-low chip enable and an active-low output enable. Two flags stand in for analog levels. The program-voltage flag is the raised level on the shared output-enable pin. The identification flag is the high level on address bit 9. From these pins the block decodes standby, output disable, read, identification read, program, and program inhibit. Verify is an ordinary read taken after programming. The outputs are registered, so every read result appears one clock after the controls and address are sampled. A tri-state buffer is modelled by `dout_en`, and `dout` is zero whenever `dout_en` is low.

A program pulse holds chip enable low while the program-voltage flag is set. The write is committed when chip enable rises, using the address and data sampled at that edge. It is committed only if the pulse lasted at least `MIN_PW` clock cycles.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset `dout_en` and `dout` are 0, and every location that has never been programmed reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp`=0 and `id_hv`=0, the byte at `addr` appears on `dout` with `dout_en`=1 one clock after sampling.
- R3: With `ce_n`=1 the block is in standby: one clock later `dout_en`=0 and `dout`=0, whatever the other inputs are.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp`=0, the outputs are disabled one clock later (`dout_en`=0, `dout`=0).
- R5: In a read with `id_hv`=1 and every address bit other than bits 0 and 9 low, `dout` is 0x1E when `addr[0]`=0 and 0x0D when `addr[0]`=1.
- R6: In a read with `id_hv`=1 and any address bit other than bits 0 and 9 set, `dout` is 0xFF.
- R7: While `vpp`=1, the outputs are disabled one clock later. A low pulse on `ce_n` lasting at least `MIN_PW` sampled clocks, ended by a clock that samples `ce_n`=1 with `vpp`=1, writes `din` into `addr` as sampled at that ending clock.
- R8: A pulse shorter than `MIN_PW` clocks leaves memory unchanged. A pulse during which `vpp` falls also leaves memory unchanged.
- R9: With `vpp`=1 and `ce_n` held high (program inhibit), memory is unchanged.
- R10: Programming stores the bitwise AND of the old byte and `din`, so a bit that is 0 never returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of outputs and pulse counter (memory contents are kept) |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| ce_n | input | 1 | Active-low chip enable; also the program pulse |
| oe_n | input | 1 | Active-low output enable |
| vpp | input | 1 | Program-voltage flag on the shared output-enable pin |
| id_hv | input | 1 | High-voltage flag on address bit 9 selecting identification |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Output driver enable (0 = high impedance) |

## Verification
The bench builds the block with `ADDR_W`=10 and `MIN_PW`=3. With these values address bit 9 is the top bit, so the identification flag can be checked against every other bit. A pulse of 2 cycles falls one short of the minimum, and a pulse of 3 cycles meets it exactly, so the write boundary is exercised from both sides. A behavioural model keeps an associative array of programmed bytes and its own pulse counter. The model predicts `dout` and `dout_en` on every clock, so a write in every mode is observed only through later reads at the ports.

// File: rtl/otp_byte_mem.sv
module otp_byte_mem #(
  parameter int ADDR_W = 12,
  parameter int MIN_PW = 4,
  parameter int ID_BIT = 9,
  parameter logic [7:0] MFR_CODE = 8'h1E,
  parameter logic [7:0] DEV_CODE = 8'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp,
  input  logic              id_hv,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(MIN_PW + 1);
  localparam logic [ADDR_W-1:0] ID_MASK = ~((ADDR_W'(1) << ID_BIT) | ADDR_W'(1));
  localparam logic [CW-1:0] PW_LIM = CW'(MIN_PW);

  logic [7:0] cells [DEPTH];
  logic [CW-1:0] pw_cnt;

  // R1: unprogrammed cells hold all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
  end

  wire rd_sel   = !ce_n && !oe_n && !vpp;
  wire id_sel   = rd_sel && id_hv;
  wire id_clean = (addr & ID_MASK) == '0;
  wire [7:0] id_byte = !id_clean ? 8'hFF : (addr[0] ? DEV_CODE : MFR_CODE);
  wire commit   = vpp && ce_n && (pw_cnt >= PW_LIM);

  // R7/R8: count sampled low cycles of the program pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pw_cnt <= '0;
    else if (vpp && !ce_n)
      pw_cnt <= (pw_cnt == PW_LIM) ? pw_cnt : pw_cnt + 1'b1;
    else
      pw_cnt <= '0;
  end

  // R10: programming only clears bits
  always_ff @(posedge clk) begin
    if (rst_n && commit)
      cells[addr] <= cells[addr] & din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= 8'h00;
    end else begin
      dout_en <= rd_sel;
      dout    <= id_sel ? id_byte : (rd_sel ? cells[addr] : 8'h00);
    end
  end
endmodule

module otp_byte_mem_chk #(
  parameter int ADDR_W = 12,
  parameter int ID_BIT = 9,
  parameter logic [7:0] MFR_CODE = 8'h1E,
  parameter logic [7:0] DEV_CODE = 8'h0D
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp,
  input logic              id_hv,
  input logic [7:0]        dout,
  input logic              dout_en
);
  localparam logic [ADDR_W-1:0] ID_ADDR = ADDR_W'(1) << ID_BIT;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !dout_en || rst_n); // R1
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !ce_n && !oe_n && !vpp) |=> dout_en); // R2
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dout_en && dout == 8'h00)); // R3
  AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && !vpp) |=> !dout_en); // R4
  AST_ID_MAKER: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp && id_hv && addr == ID_ADDR) |=> dout == MFR_CODE); // R5
  AST_ID_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp && id_hv && addr == (ID_ADDR | ADDR_W'(1))) |=> dout == DEV_CODE); // R5
  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    vpp |=> !dout_en); // R7
endmodule

bind otp_byte_mem otp_byte_mem_chk #(
  .ADDR_W(ADDR_W), .ID_BIT(ID_BIT), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp(vpp), .id_hv(id_hv), .dout(dout), .dout_en(dout_en)
);

// File: tb/otp_byte_mem_test.sv
module otp_byte_mem_test;
  localparam int AW = 10;
  localparam int PW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic ce_n = 1, oe_n = 1, vpp = 0, id_hv = 0;
  logic [7:0] dout;
  logic dout_en;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  otp_byte_mem #(.ADDR_W(AW), .MIN_PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .vpp(vpp), .id_hv(id_hv), .dout(dout), .dout_en(dout_en));

  logic [7:0] mdl [int];
  int run = 0;
  logic [7:0] exp_d = 0;
  logic exp_en = 0;
  string exp_tag = "R1";
  bit armed = 0;

  function automatic logic [7:0] peek(int a);
    return mdl.exists(a) ? mdl[a] : 8'hFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_en = 0; exp_d = 0; run = 0; exp_tag = "R1";
    end else begin
      armed = 1;
      if (ce_n) begin
        exp_en = 0; exp_d = 0; exp_tag = vpp ? "R9" : "R3";
      end else if (vpp) begin
        exp_en = 0; exp_d = 0; exp_tag = "R7";
      end else if (oe_n) begin
        exp_en = 0; exp_d = 0; exp_tag = "R4";
      end else if (id_hv) begin
        exp_en = 1;
        if ((int'(addr) & ~((1 << 9) | 1)) != 0) begin
          exp_d = 8'hFF; exp_tag = "R6";
        end else begin
          exp_d = addr[0] ? 8'h0D : 8'h1E; exp_tag = "R5";
        end
      end else begin
        exp_en = 1; exp_d = peek(int'(addr)); exp_tag = phase;
      end
      if (vpp && !ce_n) run++;
      else begin
        if (vpp && ce_n && run >= PW) mdl[int'(addr)] = peek(int'(addr)) & din;
        run = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      n_cmp++;
      if (dout_en !== exp_en || dout !== exp_d) begin
        n_bad++;
        $display("FAIL %s: got en=%0b dout=%02h, expected en=%0b dout=%02h",
                 exp_tag, dout_en, dout, exp_en, exp_d);
      end
    end
  end

  task automatic drive(input logic c, o, v, h, input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp = v; id_hv = h; addr = AW'(a); din = d;
  endtask

  task automatic rd(input int a);
    drive(0, 0, 0, 0, a, 8'h00);
  endtask

  task automatic prog(input int a, input logic [7:0] d, input int width);
    drive(1, 1, 1, 0, a, d);
    for (int i = 0; i < width; i++) drive(0, 1, 1, 0, a, d);
    drive(1, 1, 1, 0, a, d);
    drive(1, 1, 0, 0, a, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked directly before release
    n_cmp++;
    if (dout_en !== 0 || dout !== 0) begin
      n_bad++;
      $display("FAIL R1: got en=%0b dout=%02h, expected en=0 dout=00", dout_en, dout);
    end
    rst_n = 1;
    phase = "R1";
    rd(5); rd(1023); rd(0);
    phase = "R7";
    prog(5, 8'hA5, PW); rd(5);
    prog(12, 8'h3C, PW + 2); rd(12);
    phase = "R8";
    prog(6, 8'h00, PW - 1); rd(6);
    drive(1, 1, 1, 0, 7, 8'h00);
    drive(0, 1, 1, 0, 7, 8'h00); drive(0, 1, 1, 0, 7, 8'h00);
    drive(0, 1, 0, 0, 7, 8'h00); drive(1, 1, 0, 0, 7, 8'h00);
    drive(1, 1, 1, 0, 7, 8'h00); drive(1, 1, 0, 0, 7, 8'h00);
    rd(7);
    phase = "R9";
    for (int i = 0; i < 6; i++) drive(1, 0, 1, 0, 9, 8'h00);
    drive(1, 1, 0, 0, 9, 8'h00);
    rd(9);
    phase = "R10";
    prog(5, 8'h5A, PW); rd(5);
    prog(12, 8'hF3, PW); rd(12);
    prog(12, 8'hFF, PW); rd(12);
    // R4 and R3
    drive(0, 1, 0, 0, 5, 8'h00); drive(0, 1, 0, 1, 512, 8'h00);
    drive(1, 0, 0, 0, 5, 8'h00); drive(1, 0, 0, 1, 513, 8'h00);
    // R5 and R6
    drive(0, 0, 0, 1, 512, 8'h00); drive(0, 0, 0, 1, 513, 8'h00);
    drive(0, 0, 0, 1, 516, 8'h00); drive(0, 0, 0, 1, 0, 8'h00);
    drive(0, 0, 0, 1, 1, 8'h00); drive(0, 0, 0, 1, 1023, 8'h00);
    phase = "R2";
    for (int i = 0; i < 16; i++) rd(i);
    rd(5); rd(12); rd(512);
    drive(1, 1, 0, 0, 0, 8'h00);
    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule